// File: doc/BRIEF.md
# Gated BCD Event Counter with Readout

This block is a multi-digit decimal event counter for a frequency or totalizing instrument. Each rising edge of the count clock is one event. An external gate window, brought into the clock domain through a two-stage synchronizer, decides which edges are counted. Counted events advance a units digit in BCD, and each digit passes its carry to the next higher one, so the chain holds a decimal count.

A display strobe copies every digit of the live count into a bank of holding registers. The live chain keeps counting and is not disturbed. A display system then picks one held digit at a time with a binary slot index (0 = units) and gets back that digit with a valid flag. A sticky overflow flag records a carry out of the most significant digit. Two reset inputs of opposite polarity clear the live count and the overflow flag but leave the held result in place.

Top module: `bcd_gated_counter`

## Requirements
- R1: An edge of `clk` is counted exactly when `gate` was sampled high at the edge two cycles earlier (two-flop synchronizer). The number of counts equals the number of edges at which `gate` was sampled high. Edges sampled with `gate` low leave the count unchanged.
- R2: The units digit counts 0 through 9 in BCD. A counted edge at 9 returns it to 0 and increments the next digit.
- R3: Digit k of the live chain (0 = units, NUM_DECADES digits, default 7) always equals (count / 10^k) mod 10, with every value in 0..9.
- R4: `display` high at an edge loads all digits of the live count into the holding registers. Counting continues across that edge and is not disturbed.
- R5: One edge after `slot` is sampled with a value below NUM_DECADES, `digit_out` equals the held digit at that index (index 0 = units) and `digit_valid` is 1.
- R6: One edge after `slot` is sampled with a value of NUM_DECADES or more, `digit_valid` is 0 and `digit_out` is 0.
- R7: A synchronous reset clears the live count, the gate synchronizer and `overflow`. The reset is active when `rst` is 1 or `rst_n` is 0 at an edge.
- R8: Reset does not alter the holding registers. Values read back after a reset equal those loaded by the last `display`.
- R9: A carry out of the most significant digit sets `overflow` on that edge. The flag stays 1 until reset, while the count wraps and keeps counting.
- R10: When `display` and a counted edge (including one that ripples a carry) happen at the same edge, the loaded value is the count after that edge's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock; each rising edge is one event |
| rst | input | 1 | Synchronous reset, active high |
| rst_n | input | 1 | Synchronous reset, active low |
| gate | input | 1 | Gate window, may be asynchronous to clk |
| display | input | 1 | Load live count into holding registers |
| slot | input | SLOT_W (3) | Readout digit index, 0 = units |
| digit_out | output | 4 | Selected held BCD digit, registered |
| digit_valid | output | 1 | Selected index names an existing digit |
| overflow | output | 1 | Sticky carry out of the top digit |

## Verification
The assertions assume that `display`, `slot`, `rst` and `rst_n` are synchronous to `clk` and settled at each rising edge. `gate` may change at any time because it passes through the synchronizer. Digit-range and wrap properties are disabled while either reset is active. The readout properties assume nothing about held contents, because they only relate the sampled slot to the registered output. The stimulus changes every input on the falling edge, holds each reset for two edges, and reads held digits only after at least one `display` has loaded them.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  localparam int unsigned DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;
  localparam bcd_t BCD_TOP = 4'd9;
endpackage

// File: rtl/bgc_gate_sync.sv
module bgc_gate_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic gate_async,
  output logic gate_en
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (clr) sync_q <= '0;
    else     sync_q <= {sync_q[STAGES-2:0], gate_async};
  end

  assign gate_en = sync_q[STAGES-1];

  // R7
  clr_sync_chk: assert property (@(posedge clk) clr |=> !gate_en);
endmodule

// File: rtl/bgc_decade.sv
module bgc_decade
  import bgc_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic cnt_en,
  output bcd_t digit,
  output bcd_t digit_nxt,
  output logic carry
);
  logic at_top;

  assign at_top = (digit == BCD_TOP);
  assign carry  = cnt_en && at_top;

  always_comb begin
    digit_nxt = digit;
    if (cnt_en) digit_nxt = at_top ? '0 : digit + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr) digit <= '0;
    else     digit <= digit_nxt;
  end

  // R3
  digit_range_chk: assert property (@(posedge clk) disable iff (clr) digit <= BCD_TOP);
  // R2
  digit_wrap_chk: assert property (@(posedge clk) disable iff (clr)
    (cnt_en && digit == BCD_TOP) |=> digit == '0);
  // R1
  digit_hold_chk: assert property (@(posedge clk) disable iff (clr)
    !cnt_en |=> $stable(digit));
endmodule

// File: rtl/bgc_store_readout.sv
module bgc_store_readout
  import bgc_pkg::*;
#(
  parameter int unsigned NUM_DECADES = 7,
  parameter int unsigned SLOT_W      = 3
) (
  input  logic                                clk,
  input  logic                                capture,
  input  logic [NUM_DECADES-1:0][DIGIT_W-1:0] cap_digits,
  input  logic [SLOT_W-1:0]                   slot,
  output bcd_t                                digit_out,
  output logic                                digit_valid
);
  localparam int unsigned SEL_W = SLOT_W + 1;

  logic [NUM_DECADES-1:0][DIGIT_W-1:0] held;
  bcd_t rd_digit;
  logic rd_valid;

  always_ff @(posedge clk) begin
    if (capture) held <= cap_digits;
  end

  always_comb begin
    rd_digit = '0;
    for (int i = 0; i < NUM_DECADES; i++) begin
      if (slot == SLOT_W'(i)) rd_digit = held[i];
    end
    rd_valid = ({1'b0, slot} < SEL_W'(NUM_DECADES));
  end

  always_ff @(posedge clk) begin
    digit_out   <= rd_valid ? rd_digit : '0;
    digit_valid <= rd_valid;
  end

  // R4
  load_chk: assert property (@(posedge clk) capture |=> held == $past(cap_digits));
  // R6
  bad_slot_chk: assert property (@(posedge clk)
    ({1'b0, slot} >= SEL_W'(NUM_DECADES)) |=> (!digit_valid && digit_out == '0));
  // R5
  good_slot_chk: assert property (@(posedge clk)
    ({1'b0, slot} < SEL_W'(NUM_DECADES)) |=> digit_valid);
endmodule

// File: rtl/bcd_gated_counter.sv
module bcd_gated_counter
  import bgc_pkg::*;
#(
  parameter int unsigned NUM_DECADES = 7,
  parameter int unsigned SLOT_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_n,
  input  logic              gate,
  input  logic              display,
  input  logic [SLOT_W-1:0] slot,
  output logic [3:0]        digit_out,
  output logic              digit_valid,
  output logic              overflow
);
  logic clr;
  logic gate_en;
  logic [NUM_DECADES:0] en_chain;
  logic [NUM_DECADES-1:0][DIGIT_W-1:0] live_d;
  logic [NUM_DECADES-1:0][DIGIT_W-1:0] next_d;

  assign clr = rst | ~rst_n;

  bgc_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .clr        (clr),
    .gate_async (gate),
    .gate_en    (gate_en)
  );

  assign en_chain[0] = gate_en;

  for (genvar g = 0; g < NUM_DECADES; g++) begin : g_dec
    bgc_decade u_dec (
      .clk       (clk),
      .clr       (clr),
      .cnt_en    (en_chain[g]),
      .digit     (live_d[g]),
      .digit_nxt (next_d[g]),
      .carry     (en_chain[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (clr)                        overflow <= 1'b0;
    else if (en_chain[NUM_DECADES]) overflow <= 1'b1;
  end

  bgc_store_readout #(.NUM_DECADES(NUM_DECADES), .SLOT_W(SLOT_W)) u_store (
    .clk         (clk),
    .capture     (display),
    .cap_digits  (next_d),
    .slot        (slot),
    .digit_out   (digit_out),
    .digit_valid (digit_valid)
  );

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (clr) overflow |=> overflow);
  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (clr)
    en_chain[NUM_DECADES] |=> overflow);
  // R7
  ovf_clr_chk: assert property (@(posedge clk) clr |=> !overflow);
  // R1
  units_gate_chk: assert property (@(posedge clk) disable iff (clr)
    gate_en |=> live_d[0] != $past(live_d[0]));
endmodule

// File: tb/bcd_gated_counter_tb.sv
module bcd_gated_counter_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst, rst_n, gate, display;
  logic [2:0] slot;
  logic [3:0] digit_out;
  logic digit_valid, overflow;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_gated_counter #(.NUM_DECADES(N)) dut_i (
    .clk(clk), .rst(rst), .rst_n(rst_n), .gate(gate), .display(display),
    .slot(slot), .digit_out(digit_out), .digit_valid(digit_valid), .overflow(overflow)
  );

  function automatic int dig(int v, int k);
    int p = 1;
    for (int i = 0; i < k; i++) p = p * 10;
    return (v / p) % 10;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(bit use_n);
    @(negedge clk);
    if (use_n) rst_n = 1'b0; else rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; rst_n = 1'b1;
  endtask

  task automatic run_gate(int edges);
    @(negedge clk); gate = 1'b1;
    repeat (edges) @(negedge clk);
    gate = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_display();
    @(negedge clk); display = 1'b1;
    @(negedge clk); display = 1'b0;
  endtask

  task automatic read_slot(int k, output int d, output int v);
    @(negedge clk); slot = 3'(k);
    @(negedge clk); d = digit_out; v = digit_valid;
  endtask

  task automatic check_held(int value, string req);
    int d, v;
    for (int k = 0; k < N; k++) begin
      read_slot(k, d, v);
      chk(req, d, dig(value, k));
      chk("R5", v, 1);
    end
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R7", overflow, 0);
  endtask

  task automatic t_small_count();
    do_reset(1'b1);
    run_gate(7);
    do_display();
    check_held(7, "R1");
    run_gate(3);
    do_display();
    check_held(10, "R2");
  endtask

  task automatic t_gate_low();
    do_reset(1'b0);
    repeat (50) @(negedge clk);
    do_display();
    check_held(0, "R1");
  endtask

  task automatic t_multi_digit();
    do_reset(1'b0);
    run_gate(1234);
    do_display();
    check_held(1234, "R3");
    run_gate(789);
    do_display();
    check_held(2023, "R3");
  endtask

  task automatic t_live_display();
    int hi = 0;
    do_reset(1'b0);
    @(negedge clk); gate = 1'b1;
    repeat (11) begin @(negedge clk); hi++; end
    display = 1'b1;
    @(negedge clk); hi++; display = 1'b0;
    for (int k = 0; k < N; k++) begin
      @(negedge clk); hi++; slot = 3'(k);
      @(negedge clk); hi++;
      chk("R10", digit_out, dig(10, k));
    end
    gate = 1'b0;
    repeat (3) @(negedge clk);
    do_display();
    check_held(hi, "R4");
  endtask

  task automatic t_reset_keeps();
    do_reset(1'b0);
    run_gate(56);
    do_display();
    do_reset(1'b1);
    check_held(56, "R8");
    do_display();
    check_held(0, "R7");
  endtask

  task automatic t_bad_slot();
    int d, v;
    for (int k = N; k < 8; k++) begin
      read_slot(k, d, v);
      chk("R6", v, 0);
      chk("R6", d, 0);
    end
    read_slot(N - 1, d, v);
    chk("R5", v, 1);
  endtask

  task automatic t_overflow();
    do_reset(1'b0);
    run_gate(9999);
    chk("R9", overflow, 0);
    run_gate(1);
    chk("R9", overflow, 1);
    do_display();
    check_held(0, "R9");
    run_gate(5);
    chk("R9", overflow, 1);
    do_display();
    check_held(5, "R9");
    do_reset(1'b0);
    chk("R7", overflow, 0);
  endtask

  initial begin
    rst = 1'b1; rst_n = 1'b1; gate = 1'b0; display = 1'b0; slot = '0;
    t_reset();
    t_small_count();
    t_gate_low();
    t_multi_digit();
    t_live_display();
    t_reset_keeps();
    t_bad_slot();
    t_overflow();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule